// File: doc/BRIEF.md
# MESI Snooping Line-State Controller

This block keeps the coherence state of every line of a small private cache that sits on a snooping bus next to peer caches. The core side presents one local read or write at a time. The bus side presents snoops from other masters: remote read, remote write and invalidate. For each line the controller holds one of four states: Invalid, Shared, Exclusive or Modified. It also holds the line's data word, so that it can return dirty data when a snoop hits a Modified line. When a local access needs the peers to act, the controller raises its own bus message. It can place that message on the bus in the same cycle, since the message is decoded straight from the request.

A read miss installs the line as Exclusive and issues a bus read. The controller then stalls for one cycle and samples the peers' registered shared reply. If any peer held a copy, the new line drops to Shared. A single lock register supports atomic updates. While a line is locked, every snoop to it is answered with retry and changes nothing, and the snooping master must issue it again after the lock is released. The core can still read and write the locked line.

When a snoop and a local request reach the same line in the same cycle, the snoop takes effect first. The local request is then evaluated against the state the snoop left behind.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After a synchronous active-low reset every line reads Invalid on the lookup port, with state codes Invalid=0, Shared=1, Exclusive=2, Modified=3.
- R2: A local read to an Invalid line drives a bus message with op code 0 (read) in the request cycle and installs the line as Exclusive. In the next cycle ready is low and the shared input is sampled: if it is high the line becomes Shared.
- R3: A local write to an Invalid line makes it Modified and drives a bus message with op code 1 (write) in the request cycle.
- R4: On an Exclusive line a local read leaves it Exclusive, and a local write makes it Modified. Neither drives a bus message.
- R5: On a Shared line a local read leaves it Shared, and a local write makes it Modified while driving a bus message with op code 2 (invalidate).
- R6: On a Modified line, local reads and writes keep it Modified and drive no bus message.
- R7: A snoop with op code 0 on a valid line makes it Shared and raises the shared response one cycle later. If the line was Modified, the flush flag is raised in that same cycle and the data bus carries the last locally written word.
- R8: A snoop with op code 1 or 2 on a valid line makes it Invalid and raises the shared response one cycle later. A Modified line also flushes its last written word.
- R9: A snoop to an Invalid line changes nothing, and one cycle later it raises neither flush nor shared.
- R10: A snoop to the locked line raises retry one cycle later, with no flush and no shared response, and leaves the line's state unchanged. Snoops to other lines are served normally. After the lock is cleared, a snoop to that line is served again.
- R11: When a snoop and a local write hit the same line in one cycle, the snoop response is based on the state before the cycle. The local write is decided from the state after the snoop: a Shared line invalidated by the snoop issues op code 1, not 2.
- R12: With two controllers joined on one bus, no line is ever Modified or Exclusive in one cache while it is valid in the other, once each transaction has settled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lreq_valid_i | input | 1 | Local request present |
| lreq_write_i | input | 1 | Local request is a write (else read) |
| lreq_idx_i | input | IDX_W | Local request line index |
| lreq_wdata_i | input | DATA_W | Local write data |
| lreq_ready_o | output | 1 | Controller can accept a local request |
| bus_valid_o | output | 1 | Outgoing bus message valid |
| bus_op_o | output | 2 | Outgoing op: 0 read, 1 write, 2 invalidate |
| bus_idx_o | output | IDX_W | Outgoing message line index |
| shared_in_i | input | 1 | Peers' registered shared reply |
| snp_valid_i | input | 1 | Incoming snoop valid |
| snp_op_i | input | 2 | Snoop op: 0 read, 1 write, 2 invalidate |
| snp_idx_i | input | IDX_W | Snoop line index |
| snp_shared_o | output | 1 | Registered: previous snoop hit a valid line |
| snp_flush_o | output | 1 | Registered: previous snoop flushed dirty data |
| snp_data_o | output | DATA_W | Flushed data word, zero otherwise |
| snp_retry_o | output | 1 | Registered: previous snoop deferred by the lock |
| lock_set_i | input | 1 | Lock the line given by lock_idx_i |
| lock_clr_i | input | 1 | Release the lock |
| lock_idx_i | input | IDX_W | Line to lock |
| look_idx_i | input | IDX_W | Lookup index |
| look_state_o | output | 2 | State of the looked-up line |

## Verification
The hardest cases to reach are a snoop and a local write landing on the same line in one cycle, and a snoop arriving while the line is locked. A peer cache can never produce either on its own terms. The bench therefore switches the snoop input of the controller under test to a directly driven source and presents both requests on the same edge. It then checks the snoop response, which reflects the state before the cycle, and the outgoing op code, which reflects the state after the snoop. A second phase couples two controllers through their bus and shared ports and compares every line of both against a reference model after each access, including read misses that rely on the peer's delayed shared reply.

// File: rtl/mesi_pkg.sv
// Shared encodings for the line-state controller.
// Assumes: a two-bit state and a two-bit bus op code suffice.
package mesi_pkg;

    typedef enum logic [1:0] {
        LS_I = 2'd0,
        LS_S = 2'd1,
        LS_E = 2'd2,
        LS_M = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        BOP_RD  = 2'd0,
        BOP_WR  = 2'd1,
        BOP_INV = 2'd2,
        BOP_NOP = 2'd3
    } bus_op_e;

endpackage

// File: rtl/mesi_lock_reg.sv
// Atomic-update lock: holds at most one locked line index.
// Assumes: set has priority over clear when both arrive together.
module mesi_lock_reg #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_i,
    input  logic             clr_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [IDX_W-1:0] probe_idx_i,
    output logic             hit_o
);

    logic             held_q;
    logic [IDX_W-1:0] held_idx_q;

    // Capture or drop the locked line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q     <= 1'b0;
            held_idx_q <= '0;
        end else if (set_i) begin
            held_q     <= 1'b1;
            held_idx_q <= idx_i;
        end else if (clr_i) begin
            held_q     <= 1'b0;
        end
    end

    // Report whether the probed line is the locked one.
    assign hit_o = held_q && (held_idx_q == probe_idx_i);

    // R10: a clear without a set releases every line.
    a_r10_clear_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !hit_o);

endmodule

// File: rtl/mesi_snoop_eval.sv
// Snoop next-state logic for one line.
// Assumes: the caller selects the addressed line's current state and
// lock status; op code 3 is treated as no snoop.
module mesi_snoop_eval
    import mesi_pkg::*;
(
    input  logic       snp_valid_i,
    input  logic [1:0] snp_op_i,
    input  line_st_e   cur_i,
    input  logic       locked_i,
    output logic       act_o,
    output line_st_e   nxt_o,
    output logic       flush_o,
    output logic       shared_o,
    output logic       retry_o
);

    // Decide the snoop outcome from the current line state.
    always_comb begin
        act_o    = 1'b0;
        nxt_o    = cur_i;
        flush_o  = 1'b0;
        shared_o = 1'b0;
        retry_o  = 1'b0;
        if (snp_valid_i) begin
            if (locked_i) begin
                retry_o = 1'b1;
            end else if (cur_i != LS_I) begin
                case (snp_op_i)
                    BOP_RD: begin
                        act_o    = 1'b1;
                        shared_o = 1'b1;
                        nxt_o    = LS_S;
                        flush_o  = (cur_i == LS_M);
                    end
                    BOP_WR, BOP_INV: begin
                        act_o    = 1'b1;
                        shared_o = 1'b1;
                        nxt_o    = LS_I;
                        flush_o  = (cur_i == LS_M);
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/mesi_local_eval.sv
// Local-request next-state logic for one line.
// Assumes: st_i is the line state after any same-cycle snoop.
module mesi_local_eval
    import mesi_pkg::*;
(
    input  logic       fire_i,
    input  logic       write_i,
    input  line_st_e   st_i,
    output logic       upd_o,
    output line_st_e   nxt_o,
    output logic       bus_vld_o,
    output logic [1:0] bus_op_o,
    output logic       wait_o
);

    // Decide the new state and any bus message for the local access.
    always_comb begin
        upd_o     = 1'b0;
        nxt_o     = st_i;
        bus_vld_o = 1'b0;
        bus_op_o  = BOP_NOP;
        wait_o    = 1'b0;
        if (fire_i) begin
            if (write_i) begin
                upd_o = 1'b1;
                nxt_o = LS_M;
                if (st_i == LS_I) begin
                    bus_vld_o = 1'b1;
                    bus_op_o  = BOP_WR;
                end else if (st_i == LS_S) begin
                    bus_vld_o = 1'b1;
                    bus_op_o  = BOP_INV;
                end
            end else if (st_i == LS_I) begin
                upd_o     = 1'b1;
                nxt_o     = LS_E;
                bus_vld_o = 1'b1;
                bus_op_o  = BOP_RD;
                wait_o    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/mesi_line_ctrl.sv
// Coherence state tracker for a small private cache on a snooping bus.
// Holds per-line state and data, applies snoops before same-cycle local
// requests, stalls one cycle after a read miss to take the peers' shared
// reply, and defers snoops to a locked line with retry.
// Assumes: NUM_LINES is a power of two; one local request and one snoop
// per cycle at most; bus arbitration is done outside.
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter  int NUM_LINES = 8,
    parameter  int DATA_W    = 32,
    localparam int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lreq_valid_i,
    input  logic              lreq_write_i,
    input  logic [IDX_W-1:0]  lreq_idx_i,
    input  logic [DATA_W-1:0] lreq_wdata_i,
    output logic              lreq_ready_o,
    output logic              bus_valid_o,
    output logic [1:0]        bus_op_o,
    output logic [IDX_W-1:0]  bus_idx_o,
    input  logic              shared_in_i,
    input  logic              snp_valid_i,
    input  logic [1:0]        snp_op_i,
    input  logic [IDX_W-1:0]  snp_idx_i,
    output logic              snp_shared_o,
    output logic              snp_flush_o,
    output logic [DATA_W-1:0] snp_data_o,
    output logic              snp_retry_o,
    input  logic              lock_set_i,
    input  logic              lock_clr_i,
    input  logic [IDX_W-1:0]  lock_idx_i,
    input  logic [IDX_W-1:0]  look_idx_i,
    output logic [1:0]        look_state_o
);

    typedef enum logic {PH_IDLE, PH_WAIT} phase_e;

    line_st_e          st_q  [NUM_LINES];
    logic [DATA_W-1:0] dat_q [NUM_LINES];
    phase_e            ph_q;
    logic [IDX_W-1:0]  pend_q;

    logic       lfire;
    line_st_e   snp_cur;
    logic       lk_hit;
    logic       s_act, s_flush, s_shared, s_retry;
    line_st_e   s_nxt;
    line_st_e   loc_base;
    logic       l_upd, l_bvld, l_wait;
    line_st_e   l_nxt;
    logic [1:0] l_bop;
    line_st_e   pend_post;
    logic       demote;

    // Handshake: accept a local request only outside the miss-wait cycle.
    assign lreq_ready_o = (ph_q == PH_IDLE);
    assign lfire        = lreq_valid_i && lreq_ready_o;
    assign snp_cur      = st_q[snp_idx_i];

    mesi_lock_reg #(.IDX_W(IDX_W)) u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_i       (lock_set_i),
        .clr_i       (lock_clr_i),
        .idx_i       (lock_idx_i),
        .probe_idx_i (snp_idx_i),
        .hit_o       (lk_hit)
    );

    mesi_snoop_eval u_snp (
        .snp_valid_i (snp_valid_i),
        .snp_op_i    (snp_op_i),
        .cur_i       (snp_cur),
        .locked_i    (lk_hit),
        .act_o       (s_act),
        .nxt_o       (s_nxt),
        .flush_o     (s_flush),
        .shared_o    (s_shared),
        .retry_o     (s_retry)
    );

    // Local request sees the line as the snoop leaves it.
    assign loc_base = (s_act && (snp_idx_i == lreq_idx_i)) ? s_nxt : st_q[lreq_idx_i];

    mesi_local_eval u_loc (
        .fire_i    (lfire),
        .write_i   (lreq_write_i),
        .st_i      (loc_base),
        .upd_o     (l_upd),
        .nxt_o     (l_nxt),
        .bus_vld_o (l_bvld),
        .bus_op_o  (l_bop),
        .wait_o    (l_wait)
    );

    assign bus_valid_o = l_bvld;
    assign bus_op_o    = l_bop;
    assign bus_idx_o   = lreq_idx_i;

    // Demote a freshly installed line when a peer reports a copy.
    assign pend_post = (s_act && (snp_idx_i == pend_q)) ? s_nxt : st_q[pend_q];
    assign demote    = (ph_q == PH_WAIT) && shared_in_i && (pend_post == LS_E);

    // Per-line state update: snoop, then local request, then demotion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LINES; i++) st_q[i] <= LS_I;
        end else begin
            for (int i = 0; i < NUM_LINES; i++) begin
                if (l_upd && (lreq_idx_i == IDX_W'(i)))
                    st_q[i] <= l_nxt;
                else if (demote && (pend_q == IDX_W'(i)))
                    st_q[i] <= LS_S;
                else if (s_act && (snp_idx_i == IDX_W'(i)))
                    st_q[i] <= s_nxt;
            end
        end
    end

    // Line data store, written by local writes only.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_LINES; i++) begin
            if (lfire && lreq_write_i && (lreq_idx_i == IDX_W'(i)))
                dat_q[i] <= lreq_wdata_i;
        end
    end

    // Miss-wait phase tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= PH_IDLE;
            pend_q <= '0;
        end else if (l_wait) begin
            ph_q   <= PH_WAIT;
            pend_q <= lreq_idx_i;
        end else begin
            ph_q   <= PH_IDLE;
        end
    end

    // Registered snoop response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snp_shared_o <= 1'b0;
            snp_flush_o  <= 1'b0;
            snp_data_o   <= '0;
            snp_retry_o  <= 1'b0;
        end else begin
            snp_shared_o <= s_shared;
            snp_flush_o  <= s_flush;
            snp_data_o   <= s_flush ? dat_q[snp_idx_i] : '0;
            snp_retry_o  <= s_retry;
        end
    end

    // Lookup port for the core's hit check.
    assign look_state_o = st_q[look_idx_i];

    // R2: the miss-wait phase lasts exactly one cycle.
    a_r2_wait_single: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_WAIT) |=> (ph_q == PH_IDLE));

    // R2: a read-miss bus message is followed by a stall cycle.
    a_r2_miss_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (lfire && !lreq_write_i && bus_valid_o) |=> !lreq_ready_o);

    // R4: writes to an Exclusive line stay off the bus.
    a_r4_excl_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (lfire && (loc_base == LS_E)) |-> !bus_valid_o);

    // R6: accesses to a Modified line stay off the bus.
    a_r6_mod_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (lfire && (loc_base == LS_M)) |-> !bus_valid_o);

    // R7: an unlocked snoop on a Modified line flushes next cycle.
    a_r7_flush_from_m: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid_i && !lk_hit && (snp_cur == LS_M) && (snp_op_i != BOP_NOP))
        |=> snp_flush_o);

    // R9: snoops on Invalid lines stay silent.
    a_r9_invalid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid_i && (snp_cur == LS_I)) |=> (!snp_flush_o && !snp_shared_o));

    // R10: a deferred snoop leaves the line state untouched.
    a_r10_retry_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid_i && lk_hit && !(lfire && (lreq_idx_i == snp_idx_i))
         && !((ph_q == PH_WAIT) && (pend_q == snp_idx_i)))
        |=> (st_q[$past(snp_idx_i)] == $past(snp_cur)));

endmodule

// File: tb/mesi_line_ctrl_test.sv
module mesi_line_ctrl_test;
    import mesi_pkg::*;

    localparam int NL = 8;
    localparam int DW = 32;
    localparam int IW = 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n;
    logic drv_mode;

    // Controller A (uut) local side
    logic a_lv, a_lw;  logic [IW-1:0] a_li;  logic [DW-1:0] a_ld;
    logic a_rdy, a_bv; logic [1:0] a_bop;    logic [IW-1:0] a_bidx;
    logic a_sh, a_fl, a_rt;  logic [DW-1:0] a_sd;
    logic a_lks, a_lkc;  logic [IW-1:0] a_lki;
    logic [IW-1:0] a_look;  logic [1:0] a_lst;
    // Controller B (peer)
    logic b_lv, b_lw;  logic [IW-1:0] b_li;  logic [DW-1:0] b_ld;
    logic b_rdy, b_bv; logic [1:0] b_bop;    logic [IW-1:0] b_bidx;
    logic b_sh, b_fl, b_rt;  logic [DW-1:0] b_sd;
    logic [IW-1:0] b_look;  logic [1:0] b_lst;
    // Directly driven snoop source
    logic t_sv;  logic [1:0] t_sop;  logic [IW-1:0] t_sidx;  logic t_shared;

    logic          a_svld, a_shin;
    logic [1:0]    a_sop;
    logic [IW-1:0] a_sidx;
    assign a_svld = drv_mode ? t_sv     : b_bv;
    assign a_sop  = drv_mode ? t_sop    : b_bop;
    assign a_sidx = drv_mode ? t_sidx   : b_bidx;
    assign a_shin = drv_mode ? t_shared : b_sh;

    mesi_line_ctrl #(.NUM_LINES(NL), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n),
        .lreq_valid_i(a_lv), .lreq_write_i(a_lw), .lreq_idx_i(a_li), .lreq_wdata_i(a_ld),
        .lreq_ready_o(a_rdy), .bus_valid_o(a_bv), .bus_op_o(a_bop), .bus_idx_o(a_bidx),
        .shared_in_i(a_shin), .snp_valid_i(a_svld), .snp_op_i(a_sop), .snp_idx_i(a_sidx),
        .snp_shared_o(a_sh), .snp_flush_o(a_fl), .snp_data_o(a_sd), .snp_retry_o(a_rt),
        .lock_set_i(a_lks), .lock_clr_i(a_lkc), .lock_idx_i(a_lki),
        .look_idx_i(a_look), .look_state_o(a_lst));

    mesi_line_ctrl #(.NUM_LINES(NL), .DATA_W(DW)) uut_peer (
        .clk(clk), .rst_n(rst_n),
        .lreq_valid_i(b_lv), .lreq_write_i(b_lw), .lreq_idx_i(b_li), .lreq_wdata_i(b_ld),
        .lreq_ready_o(b_rdy), .bus_valid_o(b_bv), .bus_op_o(b_bop), .bus_idx_o(b_bidx),
        .shared_in_i(a_sh), .snp_valid_i(a_bv), .snp_op_i(a_bop), .snp_idx_i(a_bidx),
        .snp_shared_o(b_sh), .snp_flush_o(b_fl), .snp_data_o(b_sd), .snp_retry_o(b_rt),
        .lock_set_i(1'b0), .lock_clr_i(1'b0), .lock_idx_i('0),
        .look_idx_i(b_look), .look_state_o(b_lst));

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input string req, input longint got, input longint exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Scoreboard for snoop responses of the uut
    typedef struct {
        string       req;
        logic        fl;
        logic [DW-1:0] dat;
        logic        sh;
        logic        rt;
    } exp_t;
    exp_t expq[$];
    logic due = 1'b0;

    always @(posedge clk) due <= drv_mode && t_sv && rst_n;

    always @(negedge clk) begin
        if (due) begin
            if (expq.size() == 0) begin
                chk("scoreboard empty", 1, 0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                chk({e.req, " flush"},  a_fl, e.fl);
                chk({e.req, " data"},   a_sd, e.dat);
                chk({e.req, " shared"}, a_sh, e.sh);
                chk({e.req, " retry"},  a_rt, e.rt);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    task automatic look_a(input int idx, input logic [1:0] exp, input string req);
        a_look = IW'(idx);
        #1;
        chk(req, a_lst, exp);
    endtask

    // Local request on the uut; returns the bus message and stall flag.
    task automatic a_local(input logic w, input int idx, input logic [DW-1:0] d,
                           output logic bv, output logic [1:0] bop, output logic stalled);
        @(negedge clk);
        a_lv = 1'b1; a_lw = w; a_li = IW'(idx); a_ld = d;
        #1;
        bv = a_bv; bop = a_bop;
        @(negedge clk);
        a_lv = 1'b0;
        stalled = !a_rdy;
        if (!a_rdy) @(negedge clk);
    endtask

    task automatic push_exp(input string req, input logic fl, input logic [DW-1:0] dat,
                            input logic sh, input logic rt);
        exp_t e;
        e.req = req; e.fl = fl; e.dat = dat; e.sh = sh; e.rt = rt;
        expq.push_back(e);
    endtask

    task automatic snoop(input logic [1:0] op, input int idx, input logic fl,
                         input logic [DW-1:0] dat, input logic sh, input logic rt,
                         input string req);
        @(negedge clk);
        t_sv = 1'b1; t_sop = op; t_sidx = IW'(idx);
        push_exp(req, fl, dat, sh, rt);
        @(negedge clk);
        t_sv = 1'b0;
    endtask

    // Local write and snoop on the same line in the same cycle.
    task automatic collide(input int idx, input logic [DW-1:0] d, input logic [1:0] sop,
                           input logic fl, input logic sh, output logic [1:0] bop);
        @(negedge clk);
        a_lv = 1'b1; a_lw = 1'b1; a_li = IW'(idx); a_ld = d;
        t_sv = 1'b1; t_sop = sop; t_sidx = IW'(idx);
        push_exp("R11 collision", fl, '0, sh, 1'b0);
        #1;
        bop = a_bop;
        @(negedge clk);
        a_lv = 1'b0; t_sv = 1'b0;
    endtask

    // Reference model for the two-cache phase
    logic [1:0] ref_st [2][NL];

    task automatic sys_op(input int c, input logic w, input int idx, input logic [DW-1:0] d);
        int p;
        p = 1 - c;
        @(negedge clk);
        if (c == 0) begin a_lv = 1'b1; a_lw = w; a_li = IW'(idx); a_ld = d; end
        else        begin b_lv = 1'b1; b_lw = w; b_li = IW'(idx); b_ld = d; end
        @(negedge clk);
        a_lv = 1'b0; b_lv = 1'b0;
        @(negedge clk);
        if (w) begin
            if (ref_st[c][idx] == LS_I || ref_st[c][idx] == LS_S) ref_st[p][idx] = LS_I;
            ref_st[c][idx] = LS_M;
        end else if (ref_st[c][idx] == LS_I) begin
            if (ref_st[p][idx] != LS_I) begin
                ref_st[p][idx] = LS_S;
                ref_st[c][idx] = LS_S;
            end else begin
                ref_st[c][idx] = LS_E;
            end
        end
        for (int i = 0; i < NL; i++) begin
            logic [1:0] sa, sb;
            a_look = IW'(i); b_look = IW'(i);
            #1;
            sa = a_lst; sb = b_lst;
            chk($sformatf("R12 model A line %0d", i), sa, ref_st[0][i]);
            chk($sformatf("R12 model B line %0d", i), sb, ref_st[1][i]);
            chk($sformatf("R12 exclusivity line %0d", i),
                (((sa == LS_M || sa == LS_E) && sb != LS_I) ||
                 ((sb == LS_M || sb == LS_E) && sa != LS_I)) ? 1 : 0, 0);
        end
    endtask

    initial begin
        logic bv, stl;
        logic [1:0] bop;
        rst_n = 1'b0; drv_mode = 1'b1;
        a_lv = 0; a_lw = 0; a_li = '0; a_ld = '0; a_lks = 0; a_lkc = 0; a_lki = '0; a_look = '0;
        b_lv = 0; b_lw = 0; b_li = '0; b_ld = '0; b_look = '0;
        t_sv = 0; t_sop = '0; t_sidx = '0; t_shared = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int i = 0; i < NL; i++) look_a(i, LS_I, "R1 reset Invalid");

        // R2: read miss installs Exclusive, no peer copy
        a_local(0, 0, '0, bv, bop, stl);
        chk("R2 miss bus valid", bv, 1); chk("R2 miss op read", bop, BOP_RD);
        chk("R2 miss stall", stl, 1);   look_a(0, LS_E, "R2 miss to Exclusive");
        // R2: peer reports a copy
        t_shared = 1'b1;
        a_local(0, 1, '0, bv, bop, stl);
        t_shared = 1'b0;
        look_a(1, LS_S, "R2 demote to Shared");

        // R4: Exclusive read and write
        a_local(0, 0, '0, bv, bop, stl);
        chk("R4 E read no bus", bv, 0); look_a(0, LS_E, "R4 E read stays");
        a_local(1, 0, 32'hA5A5_0000, bv, bop, stl);
        chk("R4 E write no bus", bv, 0); look_a(0, LS_M, "R4 E write to M");

        // R6: Modified stays silent
        a_local(0, 0, '0, bv, bop, stl);
        chk("R6 M read no bus", bv, 0);
        a_local(1, 0, 32'h0000_1111, bv, bop, stl);
        chk("R6 M write no bus", bv, 0); look_a(0, LS_M, "R6 stays M");

        // R5: Shared read, then write with invalidate
        a_local(0, 1, '0, bv, bop, stl);
        chk("R5 S read no bus", bv, 0); look_a(1, LS_S, "R5 S read stays");
        a_local(1, 1, 32'h0000_2222, bv, bop, stl);
        chk("R5 S write bus", bv, 1); chk("R5 S write op inv", bop, BOP_INV);
        look_a(1, LS_M, "R5 S write to M");

        // R3: write miss
        a_local(1, 2, 32'h0000_3333, bv, bop, stl);
        chk("R3 write miss bus", bv, 1); chk("R3 write miss op", bop, BOP_WR);
        look_a(2, LS_M, "R3 to M");

        // R7: remote reads
        snoop(BOP_RD, 0, 1, 32'h0000_1111, 1, 0, "R7 read on M");
        look_a(0, LS_S, "R7 M to S");
        a_local(0, 3, '0, bv, bop, stl);
        snoop(BOP_RD, 3, 0, '0, 1, 0, "R7 read on E");
        look_a(3, LS_S, "R7 E to S");

        // R8: remote writes and invalidates
        snoop(BOP_WR, 1, 1, 32'h0000_2222, 1, 0, "R8 write on M");
        look_a(1, LS_I, "R8 M to I");
        snoop(BOP_INV, 0, 0, '0, 1, 0, "R8 inv on S");
        look_a(0, LS_I, "R8 S to I");
        a_local(0, 4, '0, bv, bop, stl);
        snoop(BOP_WR, 4, 0, '0, 1, 0, "R8 write on E");
        look_a(4, LS_I, "R8 E to I");

        // R9: snoops on Invalid lines
        snoop(BOP_RD, 5, 0, '0, 0, 0, "R9 read on I");
        snoop(BOP_INV, 5, 0, '0, 0, 0, "R9 inv on I");
        look_a(5, LS_I, "R9 stays I");

        // R10: lock defers snoops
        @(negedge clk); a_lks = 1'b1; a_lki = 3'd2;
        @(negedge clk); a_lks = 1'b0;
        snoop(BOP_RD, 2, 0, '0, 0, 1, "R10 locked retry");
        look_a(2, LS_M, "R10 locked unchanged");
        snoop(BOP_RD, 3, 0, '0, 1, 0, "R10 other line served");
        @(negedge clk); a_lkc = 1'b1;
        @(negedge clk); a_lkc = 1'b0;
        snoop(BOP_RD, 2, 1, 32'h0000_3333, 1, 0, "R10 after release");
        look_a(2, LS_S, "R10 after release to S");

        // R11: same-cycle collisions
        collide(3, 32'h0000_4444, BOP_INV, 0, 1, bop);
        chk("R11 inv first gives write op", bop, BOP_WR);
        look_a(3, LS_M, "R11 ends M");
        snoop(BOP_RD, 3, 1, 32'h0000_4444, 1, 0, "R11 new data flushed");
        t_shared = 1'b1;
        a_local(0, 6, '0, bv, bop, stl);
        t_shared = 1'b0;
        collide(6, 32'h0000_5555, BOP_RD, 0, 1, bop);
        chk("R11 read first keeps inv op", bop, BOP_INV);
        look_a(6, LS_M, "R11 ends M after read");
        repeat (2) @(negedge clk);
        chk("R7 scoreboard drained", expq.size(), 0);

        // R12: two controllers on one bus
        drv_mode = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < 2; c++)
            for (int i = 0; i < NL; i++) ref_st[c][i] = LS_I;
        sys_op(0, 0, 0, '0);
        sys_op(1, 0, 0, '0);
        sys_op(0, 1, 0, 32'h10);
        sys_op(1, 0, 0, '0);
        sys_op(1, 1, 0, 32'h20);
        sys_op(0, 1, 0, 32'h30);
        sys_op(1, 0, 1, '0);
        sys_op(1, 1, 1, 32'h40);
        sys_op(0, 0, 1, '0);
        sys_op(0, 0, 2, '0);
        sys_op(1, 1, 2, 32'h50);
        sys_op(0, 0, 7, '0);
        sys_op(0, 1, 7, 32'h60);

        finish_run();
    end

endmodule